// File: doc/BRIEF.md
# Monochrome Colour-Expansion Pixel Writer

This block sits on the host write path of a framebuffer. It takes 32-bit host data words and turns each word into one or more pixel writes. Each write carries a coordinate, a pixel value and a per-bit write enable. A mode word fixes how a data word is unpacked:
- as one full-width pixel;
- as four 8-bit indexed pixels;
- as 32 one-bit pixels, each expanded to a foreground or background colour.

Two mode options can suppress writes. A transparent background drops the zero bits of a monochrome word. A per-pixel mask drops pixels whose mask bit is clear. A plane mask then limits which bits of each pixel value may change.

The destination is a packed X/Y coordinate. It is loaded while the unit is idle, and it advances on its own after every word. A word arriving with the X-direction flag moves X by the number of pixels the word holds. A word with the Y-direction flag moves one row down and leaves X unchanged.

Host words enter on a valid/ready stream. `in_ready_o` is high only while the unit is idle. A word is taken in a cycle where `in_valid_i` and `in_ready_o` are both high, and `in_ready_o` then stays low until the word's last pixel has been written or skipped.

Pixels leave on a second valid/ready stream at most one per cycle. A pixel is transferred in a cycle where `wr_valid_o` and `wr_ready_i` are both high. While `wr_valid_o` is high and `wr_ready_i` is low, every `wr_*` output holds steady. A pixel that is suppressed costs one cycle and never raises `wr_valid_o`.

Top module: `mono_expand_writer`

## Requirements
- R1: After reset `in_ready_o` is 1, `wr_valid_o` is 0, and the destination is X=0, Y=0.
- R2: Mode bits 26:24 equal to 0 give one pixel per word, and that pixel's value is the whole word. Any code other than 2 or 5 behaves the same way.
- R3: Mode bits 26:24 equal to 2 give four pixels per word. Each pixel is one byte, zero-extended, taken from bits 31:24 first and bits 7:0 last, at X, X+1, X+2 and X+3.
- R4: Mode bits 26:24 equal to 5 give 32 pixels per word. Bit 31 is the leftmost pixel. A bit of 1 emits `fg_i` and a bit of 0 emits `bg_i`.
- R5: With mode bit 11 set in the 32-pixel mode, a zero bit produces no write, but its pixel position is still consumed.
- R6: With mode bit 10 set, the pixel at offset k within a word is written only if `pix_mask_i` bit 31-k is 1. With mode bit 10 clear, `pix_mask_i` has no effect.
- R7: Every write has `wr_be_o` equal to `plane_mask_i` and `wr_data_o` equal to the pixel value ANDed with `plane_mask_i`.
- R8: For a word with `in_ydir_i`=0, the pixel at offset k goes to (X+k, Y). X then advances by the word's pixel count (1, 4 or 32).
- R9: For a word with `in_ydir_i`=1, the pixel at offset k goes to (X+k, Y). Y then advances by 1 and X is unchanged.
- R10: `dst_ld_i` sets X from `dst_i[15:0]` and Y from `dst_i[31:16]` at the next clock edge. It overrides an advance in the same cycle.
- R11: `in_ready_o` is low from the accepting edge until the word's last pixel has been written or skipped. While `wr_valid_o` is high and `wr_ready_i` is low, `wr_x_o`, `wr_y_o` and `wr_data_o` stay unchanged.
- R12: The mode is captured when a word is accepted. A change to `mode_i` while the word is in progress has no effect on that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 32 | Mode word: bits 26:24 pixels per word, bit 11 transparent background, bit 10 pixel-mask enable |
| fg_i | input | PIX_W | Foreground colour |
| bg_i | input | PIX_W | Background colour |
| pix_mask_i | input | 32 | Per-pixel mask, bit 31-k gates offset k |
| plane_mask_i | input | PIX_W | Plane mask, per-bit write enable |
| dst_ld_i | input | 1 | Load the destination coordinate |
| dst_i | input | 2*COORD_W | Destination: Y in the high half, X in the low half |
| in_valid_i | input | 1 | Host word valid |
| in_ready_o | output | 1 | Unit idle and able to take a word |
| in_data_i | input | 32 | Host data word |
| in_ydir_i | input | 1 | 0: advance X after the word, 1: advance Y |
| wr_valid_o | output | 1 | Pixel write valid |
| wr_ready_i | input | 1 | Pixel write accepted |
| wr_x_o | output | COORD_W | Pixel X coordinate |
| wr_y_o | output | COORD_W | Pixel Y coordinate |
| wr_data_o | output | PIX_W | Pixel value after the plane mask |
| wr_be_o | output | PIX_W | Per-bit write enable |

## Verification
The bench builds the unit with its default parameters: 32-bit pixels and 16-bit coordinates. With pixels as wide as the host word, a one-pixel word passes through unchanged. A plane mask with alternating byte lanes can then show both masked and kept bits in a single write. Coordinates stay far from the 16-bit limit, so the bench checks every advance as plain addition. A back-pressure pattern on `wr_ready_i` makes the unit hold pixels mid-word, skip suppressed pixels and change its mode input while stalled.

// File: rtl/mexp_pkg.sv
package mexp_pkg;
  localparam int HOST_W        = 32;
  localparam int PPW_LSB       = 24;
  localparam int TRANSP_BIT    = 11;
  localparam int PMASK_EN_BIT  = 10;

  typedef enum logic [1:0] {
    FMT_DIRECT = 2'd0,
    FMT_INDEX8 = 2'd1,
    FMT_MONO   = 2'd2
  } fmt_e;

  typedef struct packed {
    fmt_e fmt;
    logic transp;
    logic use_pmask;
  } mode_t;

  function automatic fmt_e decode_fmt(input logic [2:0] code);
    case (code)
      3'd2:    return FMT_INDEX8;
      3'd5:    return FMT_MONO;
      default: return FMT_DIRECT;
    endcase
  endfunction

  function automatic mode_t decode_mode(input logic [HOST_W-1:0] m);
    mode_t r;
    r.fmt       = decode_fmt(m[PPW_LSB+2:PPW_LSB]);
    r.transp    = m[TRANSP_BIT];
    r.use_pmask = m[PMASK_EN_BIT];
    return r;
  endfunction

  function automatic logic [5:0] fmt_pixels(input fmt_e f);
    case (f)
      FMT_INDEX8: return 6'd4;
      FMT_MONO:   return 6'd32;
      default:    return 6'd1;
    endcase
  endfunction
endpackage

// File: rtl/mexp_pixel_sel.sv
module mexp_pixel_sel import mexp_pkg::*; #(
  parameter int WORD_W = 32,
  parameter int PIX_W  = 32,
  localparam int IDX_W = $clog2(WORD_W)
) (
  input  mode_t              mode_i,
  input  logic [WORD_W-1:0]  word_i,
  input  logic [IDX_W-1:0]   idx_i,
  input  logic [PIX_W-1:0]   fg_i,
  input  logic [PIX_W-1:0]   bg_i,
  input  logic [WORD_W-1:0]  pix_mask_i,
  input  logic [PIX_W-1:0]   plane_mask_i,
  output logic [PIX_W-1:0]   pix_data_o,
  output logic [PIX_W-1:0]   pix_be_o,
  output logic               pix_skip_o
);
  logic [WORD_W-1:0] byte_sh, bit_sh, mask_sh;
  logic [7:0]        byte_v;
  logic              mono_bit, mask_bit;
  logic [PIX_W-1:0]  raw;

  always_comb begin
    byte_sh  = word_i << (8 * idx_i[1:0]);
    bit_sh   = word_i << idx_i;
    mask_sh  = pix_mask_i << idx_i;
    byte_v   = byte_sh[WORD_W-1 -: 8];
    mono_bit = bit_sh[WORD_W-1];
    mask_bit = mask_sh[WORD_W-1];
    case (mode_i.fmt)
      FMT_INDEX8: raw = PIX_W'(byte_v);
      FMT_MONO:   raw = mono_bit ? fg_i : bg_i;
      default:    raw = PIX_W'(word_i);
    endcase
    pix_data_o = raw & plane_mask_i;
    pix_be_o   = plane_mask_i;
    pix_skip_o = (mode_i.transp && (mode_i.fmt == FMT_MONO) && !mono_bit) ||
                 (mode_i.use_pmask && !mask_bit);
  end
endmodule

// File: rtl/mexp_seq.sv
module mexp_seq #(
  parameter int WORD_W = 32,
  localparam int IDX_W = $clog2(WORD_W),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept_i,
  input  logic [CNT_W-1:0] npix_i,
  input  logic             advance_i,
  output logic             busy_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             word_done_o
);
  logic [CNT_W-1:0] npix_q;
  logic             last;

  assign last        = (CNT_W'(idx_o) == npix_q - 1'b1);
  assign word_done_o = advance_i && last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_o <= 1'b0;
      idx_o  <= '0;
      npix_q <= CNT_W'(1);
    end else if (accept_i) begin
      busy_o <= 1'b1;
      idx_o  <= '0;
      npix_q <= npix_i;
    end else if (advance_i) begin
      if (last) busy_o <= 1'b0;
      else      idx_o  <= idx_o + 1'b1;
    end
  end

  assert_idx_in_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (CNT_W'(idx_o) < npix_q));
  assert_accept_starts_R11: assert property (@(posedge clk) disable iff (!rst_n)
    accept_i |=> (busy_o && idx_o == '0));
endmodule

// File: rtl/mexp_dest.sv
module mexp_dest #(
  parameter int COORD_W = 16,
  parameter int STEP_W  = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ld_i,
  input  logic [2*COORD_W-1:0] ld_val_i,
  input  logic                 adv_x_i,
  input  logic [STEP_W-1:0]    step_i,
  input  logic                 adv_y_i,
  output logic [COORD_W-1:0]   x_o,
  output logic [COORD_W-1:0]   y_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x_o <= '0;
      y_o <= '0;
    end else if (ld_i) begin
      x_o <= ld_val_i[COORD_W-1:0];
      y_o <= ld_val_i[2*COORD_W-1:COORD_W];
    end else begin
      if (adv_x_i) x_o <= x_o + COORD_W'(step_i);
      if (adv_y_i) y_o <= y_o + 1'b1;
    end
  end

  assert_load_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ld_i |=> ({y_o, x_o} == $past(ld_val_i)));
  assert_row_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_y_i && !ld_i) |=> (y_o == COORD_W'($past(y_o) + 1'b1)));
  assert_col_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_x_i && !ld_i) |=> (x_o == COORD_W'($past(x_o) + $past(step_i))));
endmodule

// File: rtl/mono_expand_writer.sv
module mono_expand_writer import mexp_pkg::*; #(
  parameter int PIX_W   = 32,
  parameter int COORD_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [31:0]          mode_i,
  input  logic [PIX_W-1:0]     fg_i,
  input  logic [PIX_W-1:0]     bg_i,
  input  logic [31:0]          pix_mask_i,
  input  logic [PIX_W-1:0]     plane_mask_i,
  input  logic                 dst_ld_i,
  input  logic [2*COORD_W-1:0] dst_i,
  input  logic                 in_valid_i,
  output logic                 in_ready_o,
  input  logic [31:0]          in_data_i,
  input  logic                 in_ydir_i,
  output logic                 wr_valid_o,
  input  logic                 wr_ready_i,
  output logic [COORD_W-1:0]   wr_x_o,
  output logic [COORD_W-1:0]   wr_y_o,
  output logic [PIX_W-1:0]     wr_data_o,
  output logic [PIX_W-1:0]     wr_be_o
);
  localparam int WORD_W = HOST_W;
  localparam int IDX_W  = $clog2(WORD_W);
  localparam int CNT_W  = IDX_W + 1;

  mode_t              mode_q;
  logic [WORD_W-1:0]  word_q;
  logic               ydir_q;
  logic               busy, accept, advance, word_done, pix_skip;
  logic [IDX_W-1:0]   idx;
  logic [CNT_W-1:0]   npix_in;
  logic [COORD_W-1:0] cur_x, cur_y;

  assign in_ready_o = !busy;
  assign accept     = in_valid_i && !busy;
  assign npix_in    = CNT_W'(fmt_pixels(decode_fmt(mode_i[PPW_LSB+2:PPW_LSB])));
  assign advance    = busy && (pix_skip || wr_ready_i);
  assign wr_valid_o = busy && !pix_skip;
  assign wr_x_o     = cur_x + COORD_W'(idx);
  assign wr_y_o     = cur_y;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      word_q <= '0;
      ydir_q <= 1'b0;
    end else if (accept) begin
      mode_q <= decode_mode(mode_i);
      word_q <= in_data_i;
      ydir_q <= in_ydir_i;
    end
  end

  mexp_pixel_sel #(.WORD_W(WORD_W), .PIX_W(PIX_W)) u_sel (
    .mode_i       (mode_q),
    .word_i       (word_q),
    .idx_i        (idx),
    .fg_i         (fg_i),
    .bg_i         (bg_i),
    .pix_mask_i   (pix_mask_i),
    .plane_mask_i (plane_mask_i),
    .pix_data_o   (wr_data_o),
    .pix_be_o     (wr_be_o),
    .pix_skip_o   (pix_skip)
  );

  mexp_seq #(.WORD_W(WORD_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept_i    (accept),
    .npix_i      (npix_in),
    .advance_i   (advance),
    .busy_o      (busy),
    .idx_o       (idx),
    .word_done_o (word_done)
  );

  mexp_dest #(.COORD_W(COORD_W), .STEP_W(CNT_W)) u_dest (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_i     (dst_ld_i),
    .ld_val_i (dst_i),
    .adv_x_i  (word_done && !ydir_q),
    .step_i   (CNT_W'(fmt_pixels(mode_q.fmt))),
    .adv_y_i  (word_done && ydir_q),
    .x_o      (cur_x),
    .y_o      (cur_y)
  );

  assert_hold_stalled_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_o && !wr_ready_i) |=>
      (wr_valid_o && $stable(wr_x_o) && $stable(wr_y_o) && $stable(wr_data_o)));
  assert_data_within_be_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o |-> ((wr_data_o & ~wr_be_o) == '0));
  assert_mode_frozen_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready_o && $past(!in_ready_o)) |-> $stable(mode_q));
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready_o |-> !wr_valid_o);
endmodule

// File: tb/tb_mono_expand_writer.sv
module tb_mono_expand_writer;
  logic clk = 0, rst_n = 0;
  logic [31:0] mode_i = 0, fg_i = 0, bg_i = 0, pix_mask_i = 32'hFFFF_FFFF, plane_mask_i = 32'hFFFF_FFFF;
  logic dst_ld_i = 0; logic [31:0] dst_i = 0;
  logic in_valid_i = 0, in_ready_o, in_ydir_i = 0; logic [31:0] in_data_i = 0;
  logic wr_valid_o, wr_ready_i = 1;
  logic [15:0] wr_x_o, wr_y_o; logic [31:0] wr_data_o, wr_be_o;

  mono_expand_writer dut (.*);

  always #10 clk = ~clk;

  int total = 0, bad = 0, cyc = 0;
  bit stall_on = 0, finished = 0;
  int cap_n = 0, e_n = 0;
  logic [15:0] cap_x[64], cap_y[64], e_x[64], e_y[64];
  logic [31:0] cap_d[64], cap_be[64], e_d[64], e_be[64];
  bit prev_stall = 0; logic [63:0] prev_v;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin bad++; $display("FAIL %s act=%0h exp=%0h", req, act, exp); end
  endtask

  initial forever begin
    @(posedge clk); #2; cyc++;
    wr_ready_i = stall_on ? (cyc % 3 != 1) : 1'b1;
  end

  always @(negedge clk) if (rst_n) begin
    if (prev_stall) chk(wr_valid_o && {wr_x_o, wr_y_o, wr_data_o} == prev_v, "R11 hold",
                        {wr_x_o, wr_y_o, wr_data_o}, prev_v);
    prev_stall = wr_valid_o && !wr_ready_i;
    prev_v = {wr_x_o, wr_y_o, wr_data_o};
    if (wr_valid_o && wr_ready_i && cap_n < 64) begin
      cap_x[cap_n] = wr_x_o; cap_y[cap_n] = wr_y_o;
      cap_d[cap_n] = wr_data_o; cap_be[cap_n] = wr_be_o; cap_n++;
    end
  end

  task automatic build_exp(input logic [31:0] md, input logic [31:0] w, input int x0, input int y0);
    int n;
    e_n = 0;
    case (md[26:24]) 3'd2: n = 4; 3'd5: n = 32; default: n = 1; endcase
    for (int k = 0; k < n; k++) begin
      logic [31:0] v; bit wr;
      wr = 1;
      if (n == 1) v = w;
      else if (n == 4) v = {24'd0, w[31-8*k -: 8]};
      else v = w[31-k] ? fg_i : bg_i;
      if (n == 32 && md[11] && !w[31-k]) wr = 0;
      if (md[10] && !pix_mask_i[31-k]) wr = 0;
      if (wr) begin
        e_x[e_n] = 16'(x0 + k); e_y[e_n] = 16'(y0);
        e_d[e_n] = v & plane_mask_i; e_be[e_n] = plane_mask_i; e_n++;
      end
    end
  endtask

  task automatic send(input logic [31:0] w, input bit ydir, input bit chg, input logic [31:0] md2);
    @(posedge clk); #2; in_valid_i = 1; in_data_i = w; in_ydir_i = ydir;
    do @(negedge clk); while (!in_ready_o);
    @(posedge clk); #2; in_valid_i = 0;
    if (chg) mode_i = md2;
    @(negedge clk);
    chk(!in_ready_o, "R11 ready low", in_ready_o, 0);
    do @(negedge clk); while (!in_ready_o);
  endtask

  task automatic word(input string tag, input logic [31:0] w, input bit ydir, input int x0, input int y0);
    cap_n = 0;
    build_exp(mode_i, w, x0, y0);
    send(w, ydir, 0, 0);
    chk(cap_n == e_n, {tag, " count"}, cap_n, e_n);
    for (int i = 0; i < e_n && i < cap_n; i++) begin
      chk({cap_x[i], cap_y[i]} == {e_x[i], e_y[i]}, {tag, " xy"}, {cap_x[i], cap_y[i]}, {e_x[i], e_y[i]});
      chk({cap_d[i], cap_be[i]} == {e_d[i], e_be[i]}, {tag, " data"}, {cap_d[i], cap_be[i]}, {e_d[i], e_be[i]});
    end
  endtask

  task automatic load(input int x, input int y);
    @(posedge clk); #2; dst_ld_i = 1; dst_i = {16'(y), 16'(x)};
    @(posedge clk); #2; dst_ld_i = 0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(in_ready_o == 1 && wr_valid_o == 0, "R1 idle", {in_ready_o, wr_valid_o}, 2'b10);
    mode_i = 32'h0000_0000;
    word("R1 origin", 32'hDEAD_BEEF, 0, 0, 0);
  endtask

  task automatic t_one();
    word("R2 direct", 32'h1234_5678, 0, 1, 0);
    mode_i = 32'h0700_0000;
    word("R2 other code", 32'hCAFE_F00D, 0, 2, 0);
  endtask

  task automatic t_four();
    load(100, 20); mode_i = 32'h0200_0000;
    word("R3 bytes", 32'h1122_3344, 0, 100, 20);
    word("R8 x step4", 32'hA0B0_C0D0, 0, 104, 20);
  endtask

  task automatic t_mono();
    load(10, 5); mode_i = 32'h0500_0000; fg_i = 32'h00AA_BBCC; bg_i = 32'h0011_2233;
    word("R4 expand", 32'hA500_0001, 0, 10, 5);
    word("R8 x step32", 32'h0F0F_0000, 0, 42, 5);
  endtask

  task automatic t_transp();
    load(200, 1); mode_i = 32'h0500_0800;
    word("R5 transparent", 32'h8000_0003, 0, 200, 1);
    word("R5 pos kept", 32'h0000_0001, 0, 232, 1);
  endtask

  task automatic t_mask();
    load(300, 2); mode_i = 32'h0200_0400; pix_mask_i = 32'h5FFF_FFFF;
    word("R6 mask gate", 32'h0102_0304, 0, 300, 2);
    mode_i = 32'h0500_0C00; pix_mask_i = 32'hF0F0_F0F0;
    word("R6 mask+transp", 32'hFF00_FF0F, 0, 304, 2);
    mode_i = 32'h0200_0000; pix_mask_i = 32'h0;
    word("R6 mask off", 32'h0506_0708, 0, 336, 2);
    pix_mask_i = 32'hFFFF_FFFF;
  endtask

  task automatic t_plane();
    load(5, 6); mode_i = 32'h0; plane_mask_i = 32'h00FF_00FF;
    word("R7 plane", 32'hAABB_CCDD, 0, 5, 6);
    mode_i = 32'h0500_0000;
    word("R7 plane mono", 32'hC000_0000, 0, 6, 6);
    plane_mask_i = 32'hFFFF_FFFF;
  endtask

  task automatic t_yport();
    load(7, 3); mode_i = 32'h0200_0000;
    word("R9 row a", 32'h1020_3040, 1, 7, 3);
    word("R9 row b", 32'h5060_7080, 1, 7, 4);
    word("R10 after rows", 32'h9090_9090, 0, 7, 5);
  endtask

  task automatic t_load();
    load(1234, 567); mode_i = 32'h0;
    word("R10 load", 32'h0000_0042, 0, 1234, 567);
  endtask

  task automatic t_stall();
    load(50, 50); mode_i = 32'h0500_0800; stall_on = 1;
    word("R11 stall", 32'hF0F0_1234, 0, 50, 50);
    stall_on = 0;
  endtask

  task automatic t_modechg();
    logic [31:0] w;
    load(60, 9); mode_i = 32'h0500_0000; w = 32'h8000_0001;
    cap_n = 0; build_exp(mode_i, w, 60, 9);
    stall_on = 1;
    send(w, 0, 1, 32'h0000_0000);
    stall_on = 0;
    chk(cap_n == e_n, "R12 count", cap_n, e_n);
    for (int i = 0; i < e_n && i < cap_n; i++)
      chk(cap_d[i] == e_d[i], "R12 data", cap_d[i], e_d[i]);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    t_reset(); t_one(); t_four(); t_mono(); t_transp(); t_mask();
    t_plane(); t_yport(); t_load(); t_stall(); t_modechg();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule